// File: doc/BRIEF.md
# Multi-Page Message-Signalled Interrupt File

This block keeps interrupt state for several independent pages: one main page for the supervisor or machine context, plus guest pages. Each page holds a pending bit and an enable bit for every interrupt identity, a one-bit delivery switch and a priority threshold. Message writes arrive on a set-pending strobe that names a page and an identity. Software reaches each page through a register port that reads and writes with a mask.

For every page the block continuously finds the lowest-numbered identity that is both pending and enabled and lies below the page threshold. It drives one interrupt line per page from that result. A masked write to the page's top-identity register claims that identity by clearing its pending bit. The identity count is a power of two from 64 to 2048. Candidate selection can be a flat scan or a two-level search over 32-bit words, chosen by a parameter.

Top module: `msi_intr_file`

## Requirements
- R1: After reset every pending bit, enable bit, delivery bit and threshold of every page is zero, every register reads 0 and every interrupt line is low.
- R2: A set-pending strobe with page below NUM_PAGES and identity in 1..NUM_IDS-1 sets that pending bit at the next clock edge. A strobe with identity 0, an identity of NUM_IDS or more, or a page of NUM_PAGES or more changes nothing.
- R3: Identity 0 can never be pending or enabled. Bit 0 of pending word 0 and of enable word 0 always reads 0 and ignores writes.
- R4: Selects 0x40+n and 0x80+n address pending word n and enable word n, for n below NUM_IDS/32, and bit b of word n is identity 32n+b. A write stores (old & ~mask) | (data & mask). The read data in the same cycle shows the value before the write. Word indices n of NUM_IDS/32 or more read 0 and ignore writes.
- R5: Select 0x00 is the delivery register. Only bit 0 is stored, and the other bits read 0.
- R6: Select 0x01 is the threshold register. Only bits 10:0 are stored, under the same masked write.
- R7: The top identity is the smallest identity of 1 or more that is pending and enabled. When the threshold is nonzero and no larger than NUM_IDS, only identities strictly below it count. Otherwise all identities count. With no candidate, the top identity is 0.
- R8: Select 0x02 reads the top identity in bits 26:16 and again in bits 10:0, with all other bits zero.
- R9: A write to select 0x02 with a nonzero mask ignores the data and clears the pending bit of the current top identity. A zero mask, or a top identity of 0, changes nothing.
- R10: Interrupt line p is high exactly when page p's delivery bit is set and its top identity is nonzero.
- R11: If a claim and a set-pending strobe target the same identity of the same page in one cycle, the identity stays pending.
- R12: Pages are independent. An access to page NUM_PAGES or above reads 0 and changes nothing, and any select not listed above reads 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | Set-pending strobe |
| msi_page | input | PAGE_W | Page addressed by the strobe |
| msi_data | input | 32 | Identity carried by the strobe |
| reg_valid | input | 1 | Register access this cycle |
| reg_page | input | PAGE_W | Page addressed by the access |
| reg_sel | input | 8 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_wmask | input | 32 | Write bit mask |
| reg_rdata | output | 32 | Pre-write value of the selected register (combinational) |
| irq | output | NUM_PAGES | Per-page interrupt line |

## Verification
The read data is combinational from the stored state, so it is due in the same cycle as the access. The bench samples it one nanosecond after the falling edge on which it drives the access, before the write lands. Register writes, claims and set-pending strobes take effect at the next rising edge. The top-identity word and the interrupt lines therefore show the new state one cycle after the stimulus. The bench updates its reference model at that rising edge and compares every interrupt line at the following falling-edge sample.

// File: rtl/msi_intr_pkg.sv
package msi_intr_pkg;

   localparam int WORD_W     = 32;
   localparam int ID_FIELD_W = 11;
   localparam int ID_HI_LSB  = 16;

   localparam logic [7:0] SEL_DELIVER = 8'h00;
   localparam logic [7:0] SEL_THRESH  = 8'h01;
   localparam logic [7:0] SEL_TOP     = 8'h02;

   localparam logic [1:0] GRP_CTRL = 2'b00;
   localparam logic [1:0] GRP_PEND = 2'b01;
   localparam logic [1:0] GRP_ENAB = 2'b10;

   typedef enum logic [2:0] {
      K_NONE,
      K_DELIVER,
      K_THRESH,
      K_TOP,
      K_PEND,
      K_ENAB
   } reg_kind_e;

   function automatic reg_kind_e decode_sel(input logic [7:0] s);
      reg_kind_e k;
      k = K_NONE;
      case (s[7:6])
         GRP_CTRL: begin
            if (s == SEL_DELIVER)     k = K_DELIVER;
            else if (s == SEL_THRESH) k = K_THRESH;
            else if (s == SEL_TOP)    k = K_TOP;
         end
         GRP_PEND: k = K_PEND;
         GRP_ENAB: k = K_ENAB;
         default:  k = K_NONE;
      endcase
      return k;
   endfunction

   function automatic logic [WORD_W-1:0] top_word(input logic [ID_FIELD_W-1:0] id);
      logic [WORD_W-1:0] w;
      w = '0;
      w[ID_HI_LSB +: ID_FIELD_W] = id;
      w[ID_FIELD_W-1:0]          = id;
      return w;
   endfunction

endpackage

// File: rtl/msi_intr_prio_find.sv
module msi_intr_prio_find
   import msi_intr_pkg::*;
#(
   parameter int NUM_IDS    = 64,
   parameter int FIND_STYLE = 1,
   parameter int ID_W       = 6
)(
   input  logic [NUM_IDS-1:0] cand,
   output logic [ID_W-1:0]    top_id
);

   localparam int NW = NUM_IDS / WORD_W;

   logic [NUM_IDS-1:0] live;

   always_comb begin
      live    = cand;
      live[0] = 1'b0;
   end

   generate
      if (FIND_STYLE == 0) begin : g_flat
         always_comb begin
            top_id = '0;
            for (int i = NUM_IDS - 1; i >= 1; i--) begin
               if (live[i]) top_id = ID_W'(i);
            end
         end
      end else begin : g_two_level
         logic [4:0]    lo  [NW];
         logic [NW-1:0] any;

         for (genvar w = 0; w < NW; w++) begin : g_word
            always_comb begin
               lo[w] = '0;
               for (int b = WORD_W - 1; b >= 0; b--) begin
                  if (live[w*WORD_W + b]) lo[w] = 5'(b);
               end
            end
            assign any[w] = |live[w*WORD_W +: WORD_W];
         end

         always_comb begin
            top_id = '0;
            for (int w = NW - 1; w >= 0; w--) begin
               if (any[w]) top_id = ID_W'(w * WORD_W) | ID_W'(lo[w]);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/msi_intr_page.sv
module msi_intr_page
   import msi_intr_pkg::*;
#(
   parameter int NUM_IDS    = 64,
   parameter int FIND_STYLE = 1
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_en,
   input  logic [7:0]            acc_sel,
   input  logic [WORD_W-1:0]     acc_wdata,
   input  logic [WORD_W-1:0]     acc_wmask,
   output logic [WORD_W-1:0]     acc_rdata,
   input  logic                  set_en,
   input  logic [ID_FIELD_W-1:0] set_id,
   output logic                  irq
);

   localparam int ID_W  = $clog2(NUM_IDS);
   localparam int NW    = NUM_IDS / WORD_W;
   localparam int WIX_W = $clog2(NW);

   logic [NUM_IDS-1:0]    pend_q, pend_d, enab_q, enab_d, elig, cand;
   logic                  deliv_q, deliv_d;
   logic [ID_FIELD_W-1:0] thr_q, thr_d;
   logic [ID_W-1:0]       top_id;
   logic [ID_W-1:0]       set_ix;
   reg_kind_e             kind;
   logic [5:0]            widx;
   logic                  widx_ok;
   logic                  limit_on;
   logic                  claim;

   assign kind     = decode_sel(acc_sel);
   assign widx     = acc_sel[5:0];
   assign widx_ok  = int'(widx) < NW;
   assign set_ix   = set_id[ID_W-1:0];
   assign limit_on = (thr_q != '0) && (int'(thr_q) <= NUM_IDS);
   assign claim    = acc_en && (kind == K_TOP) && (acc_wmask != '0) && (top_id != '0);

   always_comb begin
      for (int i = 0; i < NUM_IDS; i++) begin
         elig[i] = !limit_on || (i < int'(thr_q));
      end
   end

   assign cand = pend_q & enab_q & elig;

   msi_intr_prio_find #(
      .NUM_IDS    (NUM_IDS),
      .FIND_STYLE (FIND_STYLE),
      .ID_W       (ID_W)
   ) find_i (
      .cand   (cand),
      .top_id (top_id)
   );

   always_comb begin
      acc_rdata = '0;
      case (kind)
         K_DELIVER: acc_rdata[0] = deliv_q;
         K_THRESH:  acc_rdata[ID_FIELD_W-1:0] = thr_q;
         K_TOP:     acc_rdata = top_word(ID_FIELD_W'(top_id));
         K_PEND:    if (widx_ok) acc_rdata = pend_q[int'(widx[WIX_W-1:0])*WORD_W +: WORD_W];
         K_ENAB:    if (widx_ok) acc_rdata = enab_q[int'(widx[WIX_W-1:0])*WORD_W +: WORD_W];
         default:   acc_rdata = '0;
      endcase
   end

   always_comb begin
      pend_d  = pend_q;
      enab_d  = enab_q;
      deliv_d = deliv_q;
      thr_d   = thr_q;
      if (acc_en) begin
         case (kind)
            K_DELIVER: if (acc_wmask[0]) deliv_d = acc_wdata[0];
            K_THRESH:  thr_d = (thr_q & ~acc_wmask[ID_FIELD_W-1:0]) |
                               (acc_wdata[ID_FIELD_W-1:0] & acc_wmask[ID_FIELD_W-1:0]);
            K_PEND: begin
               for (int i = 0; i < NUM_IDS; i++) begin
                  if (widx_ok && (i / WORD_W == int'(widx)) && acc_wmask[i % WORD_W])
                     pend_d[i] = acc_wdata[i % WORD_W];
               end
            end
            K_ENAB: begin
               for (int i = 0; i < NUM_IDS; i++) begin
                  if (widx_ok && (i / WORD_W == int'(widx)) && acc_wmask[i % WORD_W])
                     enab_d[i] = acc_wdata[i % WORD_W];
               end
            end
            default: ;
         endcase
      end
      if (claim)  pend_d[top_id] = 1'b0;
      if (set_en) pend_d[set_ix] = 1'b1;
      pend_d[0] = 1'b0;
      enab_d[0] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= '0;
         enab_q  <= '0;
         deliv_q <= 1'b0;
         thr_q   <= '0;
      end else begin
         pend_q  <= pend_d;
         enab_q  <= enab_d;
         deliv_q <= deliv_d;
         thr_q   <= thr_d;
      end
   end

   assign irq = deliv_q && (top_id != '0);

   // R3: word 0 never shows identity 0
   p_id0_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && (kind == K_PEND || kind == K_ENAB) && widx == 6'd0) |-> !acc_rdata[0]);

   // R2: an accepted strobe lands
   p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> pend_q[$past(set_ix)]);

   // R9: a claim clears the claimed identity unless a strobe re-sets it
   p_claim_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (claim && !(set_en && set_ix == top_id)) |=> !pend_q[$past(top_id)]);

   // R11: set-pending wins over claim
   p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (claim && set_en && set_ix == top_id) |=> pend_q[$past(top_id)]);

   // R7: threshold bounds the top identity
   p_below_thr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (limit_on && top_id != '0) |-> (int'(top_id) < int'(thr_q)));

   // R10: a raised line has a real source
   p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (deliv_q && pend_q[top_id] && enab_q[top_id]));

endmodule

// File: rtl/msi_intr_file.sv
module msi_intr_file
   import msi_intr_pkg::*;
#(
   parameter int NUM_PAGES  = 3,
   parameter int PAGE_W     = 2,
   parameter int NUM_IDS    = 64,
   parameter int FIND_STYLE = 1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 msi_valid,
   input  logic [PAGE_W-1:0]    msi_page,
   input  logic [31:0]          msi_data,
   input  logic                 reg_valid,
   input  logic [PAGE_W-1:0]    reg_page,
   input  logic [7:0]           reg_sel,
   input  logic [31:0]          reg_wdata,
   input  logic [31:0]          reg_wmask,
   output logic [31:0]          reg_rdata,
   output logic [NUM_PAGES-1:0] irq
);

   generate
      if (NUM_IDS < 64 || NUM_IDS > 2048 || (NUM_IDS & (NUM_IDS - 1)) != 0) begin : g_bad_ids
         $error("NUM_IDS must be a power of two from 64 to 2048");
      end
      if (NUM_PAGES < 1 || NUM_PAGES > 64 || (2 ** PAGE_W) < NUM_PAGES) begin : g_bad_pages
         $error("NUM_PAGES must be 1..64 and fit in PAGE_W bits");
      end
   endgenerate

   logic                  msi_ok;
   logic [ID_FIELD_W-1:0] msi_id;
   logic [WORD_W-1:0]     rd [NUM_PAGES];

   assign msi_ok = msi_valid && (int'(msi_page) < NUM_PAGES) &&
                   (msi_data != 32'd0) && (msi_data < 32'(NUM_IDS));
   assign msi_id = msi_data[ID_FIELD_W-1:0];

   generate
      for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
         msi_intr_page #(
            .NUM_IDS    (NUM_IDS),
            .FIND_STYLE (FIND_STYLE)
         ) page_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_en    (reg_valid && reg_page == PAGE_W'(p)),
            .acc_sel   (reg_sel),
            .acc_wdata (reg_wdata),
            .acc_wmask (reg_wmask),
            .acc_rdata (rd[p]),
            .set_en    (msi_ok && msi_page == PAGE_W'(p)),
            .set_id    (msi_id),
            .irq       (irq[p])
         );
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      for (int p = 0; p < NUM_PAGES; p++) begin
         if (reg_page == PAGE_W'(p)) reg_rdata = rd[p];
      end
   end

   // R12: an access to a missing page reads zero
   p_missing_page_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(reg_page) >= NUM_PAGES) |-> (reg_rdata == '0));

endmodule

// File: tb/msi_intr_file_tb_top.sv
`timescale 1ns/1ps
module msi_intr_file_tb_top;

   localparam int NP = 3;
   localparam int PW = 2;
   localparam int NI = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          msi_valid = 1'b0;
   logic [PW-1:0] msi_page = '0;
   logic [31:0]   msi_data = '0;
   logic          reg_valid = 1'b0;
   logic [PW-1:0] reg_page = '0;
   logic [7:0]    reg_sel = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_wmask = '0;
   logic [31:0]   reg_rdata;
   logic [NP-1:0] irq;

   always #4 clk = ~clk;

   msi_intr_file #(.NUM_PAGES(NP), .PAGE_W(PW), .NUM_IDS(NI), .FIND_STYLE(1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .msi_valid(msi_valid), .msi_page(msi_page), .msi_data(msi_data),
      .reg_valid(reg_valid), .reg_page(reg_page), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .reg_rdata(reg_rdata),
      .irq(irq)
   );

   bit          mp [NP][NI];
   bit          me [NP][NI];
   bit          md [NP];
   logic [10:0] mt [NP];
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   function automatic int m_top(int p);
      bit lim;
      lim = (mt[p] != 0) && (int'(mt[p]) <= NI);
      for (int i = 1; i < NI; i++)
         if ((!lim || i < int'(mt[p])) && mp[p][i] && me[p][i]) return i;
      return 0;
   endfunction

   function automatic logic [31:0] m_read(int p, int sel);
      logic [31:0] v;
      v = '0;
      if (p >= NP) return v;
      if (sel == 0) v[0] = md[p];
      else if (sel == 1) v[10:0] = mt[p];
      else if (sel == 2) begin
         v[26:16] = 11'(m_top(p));
         v[10:0]  = 11'(m_top(p));
      end else if (sel >= 'h40 && sel < 'h40 + NI/32) begin
         for (int b = 0; b < 32; b++) v[b] = mp[p][(sel-'h40)*32+b];
      end else if (sel >= 'h80 && sel < 'h80 + NI/32) begin
         for (int b = 0; b < 32; b++) v[b] = me[p][(sel-'h80)*32+b];
      end
      return v;
   endfunction

   task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic op(bit mv, int mpg, int mdat, bit rv, int rpg, int sel,
                     logic [31:0] wd, logic [31:0] wm, string rq);
      logic [NP-1:0] ei;
      int tp;
      @(negedge clk);
      msi_valid = mv; msi_page = PW'(mpg); msi_data = 32'(mdat);
      reg_valid = rv; reg_page = PW'(rpg); reg_sel = 8'(sel);
      reg_wdata = wd; reg_wmask = wm;
      #1;
      if (rv) chk(rq, reg_rdata, m_read(rpg, sel));
      for (int p = 0; p < NP; p++) ei[p] = md[p] && (m_top(p) != 0);
      chk("R10", 32'(irq), 32'(ei));
      @(posedge clk);
      if (rv && rpg < NP) begin
         tp = m_top(rpg);
         if (sel == 0) begin
            if (wm[0]) md[rpg] = wd[0];
         end else if (sel == 1) mt[rpg] = (mt[rpg] & ~wm[10:0]) | (wd[10:0] & wm[10:0]);
         else if (sel == 2) begin
            if (wm != 0 && tp != 0) mp[rpg][tp] = 0;
         end else if (sel >= 'h40 && sel < 'h40 + NI/32) begin
            for (int b = 0; b < 32; b++)
               if (wm[b] && ((sel-'h40)*32+b) != 0) mp[rpg][(sel-'h40)*32+b] = wd[b];
         end else if (sel >= 'h80 && sel < 'h80 + NI/32) begin
            for (int b = 0; b < 32; b++)
               if (wm[b] && ((sel-'h80)*32+b) != 0) me[rpg][(sel-'h80)*32+b] = wd[b];
         end
      end
      if (mv && mpg < NP && mdat != 0 && mdat < NI) mp[mpg][mdat] = 1;
   endtask

   task automatic rd(int p, int sel, string rq);
      op(0, 0, 0, 1, p, sel, 32'h0, 32'h0, rq);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 190000);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      int sels [9] = '{'h00, 'h01, 'h02, 'h03, 'h40, 'h41, 'h42, 'h80, 'h81};
      void'($urandom(32'h5eed));
      for (int p = 0; p < NP; p++) begin
         md[p] = 0; mt[p] = '0;
         for (int i = 0; i < NI; i++) begin mp[p][i] = 0; me[p][i] = 0; end
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      for (int p = 0; p < NP; p++)
         foreach (sels[k]) rd(p, sels[k], "R1");
      chk("R1", 32'(irq), 32'h0);

      // R3: identity 0 cannot be set
      op(0, 0, 0, 1, 0, 'h40, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
      op(0, 0, 0, 1, 0, 'h80, 32'h0000_0001, 32'hFFFF_FFFF, "R4");
      rd(0, 'h40, "R3");
      chk("R3", reg_rdata, 32'hFFFF_FFFE);
      rd(0, 'h80, "R3");
      chk("R3", reg_rdata, 32'h0);
      op(0, 0, 0, 1, 0, 'h40, 32'h0, 32'hFFFF_FFFF, "R4");

      // R2: bad strobes ignored
      op(1, 1, 0, 0, 0, 0, 0, 0, "R2");
      op(1, 1, NI, 0, 0, 0, 0, 0, "R2");
      op(1, 3, 7, 0, 0, 0, 0, 0, "R2");
      rd(1, 'h40, "R2");
      chk("R2", reg_rdata, 32'h0);
      rd(1, 'h41, "R2");
      op(1, 1, 33, 0, 0, 0, 0, 0, "R2");
      rd(1, 'h41, "R2");
      chk("R2", reg_rdata, 32'h0000_0002);

      // R5, R6
      op(0, 0, 0, 1, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5");
      rd(0, 0, "R5");
      chk("R5", reg_rdata, 32'h1);
      op(0, 0, 0, 1, 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
      rd(0, 1, "R6");
      chk("R6", reg_rdata, 32'h7FF);
      op(0, 0, 0, 1, 0, 1, 32'h0, 32'hFFFF_FFFF, "R6");

      // R7, R8: priority and threshold
      op(1, 0, 5, 0, 0, 0, 0, 0, "R2");
      op(1, 0, 9, 0, 0, 0, 0, 0, "R2");
      op(0, 0, 0, 1, 0, 'h80, 32'h0000_0200, 32'h0000_0200, "R4");
      rd(0, 2, "R8");
      chk("R8", reg_rdata, 32'h0009_0009);
      op(0, 0, 0, 1, 0, 'h80, 32'h0000_0020, 32'h0000_0020, "R4");
      rd(0, 2, "R7");
      chk("R7", reg_rdata, 32'h0005_0005);
      op(0, 0, 0, 1, 0, 1, 32'd5, 32'h7FF, "R6");
      rd(0, 2, "R7");
      chk("R7", reg_rdata, 32'h0);
      chk("R10", 32'(irq[0]), 32'h0);
      op(0, 0, 0, 1, 0, 1, 32'd6, 32'h7FF, "R6");
      rd(0, 2, "R7");
      op(0, 0, 0, 1, 0, 1, 32'd65, 32'h7FF, "R6");
      rd(0, 2, "R7");
      op(0, 0, 0, 1, 0, 1, 32'd64, 32'h7FF, "R6");
      rd(0, 2, "R7");
      op(0, 0, 0, 1, 0, 1, 32'd0, 32'h7FF, "R6");

      // R9: claim
      op(0, 0, 0, 1, 0, 2, 32'hFFFF_FFFF, 32'h0, "R9");
      rd(0, 2, "R9");
      chk("R9", reg_rdata, 32'h0005_0005);
      op(0, 0, 0, 1, 0, 2, 32'h0, 32'h1, "R9");
      rd(0, 2, "R9");
      chk("R9", reg_rdata, 32'h0009_0009);

      // R11: claim of 9 with strobe for 9
      op(1, 0, 9, 1, 0, 2, 32'h0, 32'h1, "R11");
      rd(0, 'h40, "R11");
      chk("R11", reg_rdata & 32'h200, 32'h200);

      // R12: missing page and unknown select
      op(0, 0, 0, 1, 3, 0, 32'h1, 32'h1, "R12");
      rd(3, 0, "R12");
      chk("R12", reg_rdata, 32'h0);
      op(0, 0, 0, 1, 0, 'h03, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R12");

      // random mix
      for (int n = 0; n < 4000; n++) begin
         int s, r, pg;
         logic [31:0] wd, wm;
         s  = sels[$urandom % 9];
         pg = int'($urandom % 4);
         r  = int'($urandom % 4);
         wd = $urandom;
         if (s == 1) wd = $urandom % 80;
         wm = (r == 0) ? 32'h0 : (r == 1) ? 32'hFFFF_FFFF : $urandom;
         op($urandom % 2 == 0, int'($urandom % 4), int'($urandom % (NI + 8)),
            $urandom % 3 != 0, pg, s, wd, wm, "R4");
      end

      @(negedge clk);
      reg_valid = 0; msi_valid = 0;
      finish_run();
   end

endmodule